// File: doc/BRIEF.md
# Serial-Bus Snooping Memory Writer

This block listens, without ever driving anything, to a three-wire serial processor bus that is organised in frames of 56 bit times. One wire carries a frame marker, one carries the instruction stream and one carries a serial image of the processor's accumulator. The block counts bit phases inside each frame. It rebuilds every instruction word that is fetched, and it reacts to two opcodes. The processor treats both as no-operations, so these two opcodes are only meaningful to this device.

When the memory-write opcode is fetched, the block waits for the next frame. From that frame's accumulator image it takes a 10-bit word and a 16-bit address. It then checks whether the page selected by the address's top nibble belongs to this device and whether writes are currently allowed. If both hold, it issues a single write strobe, with address and data, to a local RAM. The other opcode flips a write-protect flag, and that flag gates every later write.

Top module: `bus_snoop_writer`

## Requirements
- R1: The phase count restarts at 0 on the first bit sampled low after the marker (`sync_i`) has been high, and then advances by one per clock up to 55 before wrapping to 0. No opcode is acted on until a first marker fall has been seen after reset.
- R2: An opcode is assembled from `isa_i` in phases 46 to 55, least significant bit first. It counts as a fetch only if `sync_i` is high in all ten of those phases, so a word that arrives with the marker low triggers nothing.
- R3: Fetching opcode 0x040 arms exactly one write, and that write takes its address and word from the frame immediately after the fetch. The arming then lapses at the end of that frame.
- R4: The write word is the 10 bits on `data_i` in phases 2 to 11, least significant bit first (accumulator bits 0 to 9). The bits in phases 12 and 13 do not reach the stored word.
- R5: The write address is the 16 bits on `data_i` in phases 14 to 29, least significant bit first (accumulator bits 12 to 27). Its top four bits (phases 26 to 29) select the page.
- R6: A write is issued only if the page's bit in `PAGE_OWNED` is set (default pages 8 and 9) and protection is off. Any other armed write is dropped, and `mem_we_o` stays low.
- R7: Fetching opcode 0x1F0 inverts the write-protect state, and `wp_o` shows the new value before the next frame's write check.
- R8: `mem_we_o` is high for exactly one clock, during the bit time of phase 33 (it is decided at phase 32), with `mem_addr_o` and `mem_wdata_o` valid in that same clock.
- R9: After reset, `mem_we_o` is low and `wp_o` equals `PROT_INIT` (default 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus bit clock, one rising edge per bit time |
| rst | input | 1 | Synchronous active-high reset |
| sync_i | input | 1 | Frame marker, high during instruction fetch bits |
| isa_i | input | 1 | Serial instruction line |
| data_i | input | 1 | Serial accumulator image line |
| mem_addr_o | output | 16 | Address of the write |
| mem_wdata_o | output | 10 | Word to be stored |
| mem_we_o | output | 1 | One-clock write strobe |
| wp_o | output | 1 | Current write-protect state |

## Verification
The assertions assume that the bus is well formed. They expect the marker to fall only at a frame boundary, so that the bit counter never resynchronises in mid-frame. They also expect reset to be held for a few clocks before the bus becomes active. The bench keeps within these assumptions by emitting only whole 56-bit frames that start on a clock edge. It raises the marker only in phases 46 to 55, and only on frames meant as fetches. It releases reset with the bus idle. A single deliberate lapse is allowed: the first frame after reset runs before the counter has locked. The only properties active in that frame are ones that the unlocked state cannot violate.

// File: rtl/bsw_pkg.sv
`timescale 1ns/1ps
package bsw_pkg;
  localparam int FRAME    = 56;
  localparam int PH_W     = $clog2(FRAME);
  localparam int OP_W     = 10;
  localparam int WORD_W   = 10;
  localparam int ADDR_W   = 16;
  localparam int PAGE_W   = 4;
  localparam int NPAGES   = 1 << PAGE_W;

  typedef logic [PH_W-1:0] ph_t;

  // first serial phase of each field
  localparam int WORD_FIRST = 2;
  localparam int ADDR_FIRST = 14;
  localparam int OP_FIRST   = 46;
  localparam int CHECK_AT   = ADDR_FIRST + ADDR_W + 2;   // 32

  localparam ph_t PH_LAST  = ph_t'(FRAME - 1);
  localparam ph_t PH_ZERO  = ph_t'(0);
  localparam ph_t PH_OP    = ph_t'(OP_FIRST);
  localparam ph_t PH_CHECK = ph_t'(CHECK_AT);
  localparam ph_t PH_STRB  = ph_t'(CHECK_AT + 1);

  localparam logic [OP_W-1:0] OPC_MEMWR  = 10'h040;
  localparam logic [OP_W-1:0] OPC_PROTGL = 10'h1F0;
endpackage

// File: rtl/bsw_phase.sv
`timescale 1ns/1ps
module bsw_phase
  import bsw_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic sync_i,
  output ph_t  ph,
  output logic lock
);
  logic sync_q;
  logic lock_q;
  ph_t  ph_q;
  logic fall;

  assign fall = sync_q & ~sync_i;

  always_comb begin
    if (fall)                ph = PH_ZERO;
    else if (ph_q == PH_LAST) ph = PH_ZERO;
    else                     ph = ph_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= 1'b0;
      lock_q <= 1'b0;
      ph_q   <= PH_ZERO;
    end else begin
      sync_q <= sync_i;
      ph_q   <= ph;
      if (fall) lock_q <= 1'b1;
    end
  end

  assign lock = lock_q;

  // R1
  ph_range_chk: assert property (@(posedge clk) disable iff (rst)
    ph_q <= PH_LAST);
  // R1
  ph_step_chk: assert property (@(posedge clk) disable iff (rst)
    (ph_q != PH_LAST) && !(sync_q & ~sync_i) |=> ph_q == $past(ph_q) + 1'b1);
endmodule

// File: rtl/bsw_shift_cap.sv
`timescale 1ns/1ps
module bsw_shift_cap
  import bsw_pkg::*;
#(
  parameter int FIRST = 2,
  parameter int W     = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  ph_t          ph,
  input  logic         bit_i,
  output logic [W-1:0] val
);
  localparam ph_t LO = ph_t'(FIRST);
  localparam ph_t HI = ph_t'(FIRST + W - 1);

  logic win;
  assign win = (ph >= LO) && (ph <= HI);

  always_ff @(posedge clk) begin
    if (rst)      val <= '0;
    else if (win) val <= {bit_i, val[W-1:1]};
  end

  // R4 R5: outside its window the field holds
  cap_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (ph < LO) |=> $stable(val));
endmodule

// File: rtl/bsw_opdec.sv
`timescale 1ns/1ps
module bsw_opdec
  import bsw_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  ph_t  ph,
  input  logic lock,
  input  logic sync_i,
  input  logic isa_i,
  output logic wr_hit,
  output logic tog_hit
);
  logic [OP_W-1:0] op;
  logic            fok;

  bsw_shift_cap #(.FIRST(OP_FIRST), .W(OP_W)) u_opcap (
    .clk(clk), .rst(rst), .ph(ph), .bit_i(isa_i), .val(op)
  );

  always_ff @(posedge clk) begin
    if (rst)              fok <= 1'b0;
    else if (ph == PH_OP) fok <= sync_i;
    else if (ph > PH_OP)  fok <= fok & sync_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_hit  <= 1'b0;
      tog_hit <= 1'b0;
    end else begin
      wr_hit  <= (ph == PH_ZERO) && lock && fok && (op == OPC_MEMWR);
      tog_hit <= (ph == PH_ZERO) && lock && fok && (op == OPC_PROTGL);
    end
  end

  // R2
  hit_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({wr_hit, tog_hit}));
  // R2
  hit_sync_chk: assert property (@(posedge clk) disable iff (rst)
    wr_hit |-> $past(sync_i, 2));
endmodule

// File: rtl/bus_snoop_writer.sv
`timescale 1ns/1ps
module bus_snoop_writer
  import bsw_pkg::*;
#(
  parameter logic [NPAGES-1:0] PAGE_OWNED = 16'h0300,
  parameter logic              PROT_INIT  = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sync_i,
  input  logic              isa_i,
  input  logic              data_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [WORD_W-1:0] mem_wdata_o,
  output logic              mem_we_o,
  output logic              wp_o
);
  ph_t               ph;
  logic              lock;
  logic              wr_hit, tog_hit;
  logic [WORD_W-1:0] word_q;
  logic [ADDR_W-1:0] addr_q;
  logic              pend;
  logic              owned;
  logic              go;

  bsw_phase u_phase (
    .clk(clk), .rst(rst), .sync_i(sync_i), .ph(ph), .lock(lock)
  );

  bsw_opdec u_dec (
    .clk(clk), .rst(rst), .ph(ph), .lock(lock), .sync_i(sync_i),
    .isa_i(isa_i), .wr_hit(wr_hit), .tog_hit(tog_hit)
  );

  bsw_shift_cap #(.FIRST(WORD_FIRST), .W(WORD_W)) u_word (
    .clk(clk), .rst(rst), .ph(ph), .bit_i(data_i), .val(word_q)
  );

  bsw_shift_cap #(.FIRST(ADDR_FIRST), .W(ADDR_W)) u_addr (
    .clk(clk), .rst(rst), .ph(ph), .bit_i(data_i), .val(addr_q)
  );

  always_ff @(posedge clk) begin
    if (rst)                 pend <= 1'b0;
    else if (wr_hit)         pend <= 1'b1;
    else if (ph == PH_LAST)  pend <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst)          wp_o <= PROT_INIT;
    else if (tog_hit) wp_o <= ~wp_o;
  end

  assign owned = PAGE_OWNED[addr_q[ADDR_W-1 -: PAGE_W]];
  assign go    = (ph == PH_CHECK) && pend && owned && !wp_o;

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_we_o    <= 1'b0;
      mem_addr_o  <= '0;
      mem_wdata_o <= '0;
    end else begin
      mem_we_o <= go;
      if (go) begin
        mem_addr_o  <= addr_q;
        mem_wdata_o <= word_q;
      end
    end
  end

  // R8
  we_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we_o |=> !mem_we_o);
  // R8
  we_phase_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we_o |-> ph == PH_STRB);
  // R6
  we_prot_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we_o |-> !wp_o);
  // R6
  we_page_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we_o |-> PAGE_OWNED[mem_addr_o[ADDR_W-1 -: PAGE_W]]);
  // R3
  we_armed_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we_o |-> pend);
  // R7
  wp_tog_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(wp_o) |-> $past(tog_hit));
endmodule

// File: tb/tb_bus_snoop_writer.sv
`timescale 1ns/1ps
module tb_bus_snoop_writer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sync_i = 1'b0, isa_i = 1'b0, data_i = 1'b0;
  logic [15:0] mem_addr_o;
  logic [9:0]  mem_wdata_o;
  logic        mem_we_o, wp_o;

  int checks = 0;
  int errors = 0;
  int we_cnt;
  int we_ph;
  logic [15:0] we_addr;
  logic [9:0]  we_data;
  bit done = 0;

  bus_snoop_writer dut (
    .clk(clk), .rst(rst), .sync_i(sync_i), .isa_i(isa_i), .data_i(data_i),
    .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o),
    .mem_we_o(mem_we_o), .wp_o(wp_o)
  );

  initial forever #2.5 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [55:0] acc(input logic [15:0] a, input logic [9:0] w,
                                      input logic [1:0] junk);
    logic [55:0] c;
    c = {28'h5A5A5A5, a, junk, w};
    return c;
  endfunction

  // one 56-bit frame; write strobes seen during it are recorded
  task automatic frame(input bit fetch, input logic [9:0] op, input logic [55:0] c);
    we_cnt = 0; we_ph = -1; we_addr = '0; we_data = '0;
    for (int p = 0; p < 56; p++) begin
      @(negedge clk);
      if (mem_we_o) begin
        we_cnt++; we_ph = p; we_addr = mem_addr_o; we_data = mem_wdata_o;
      end
      sync_i = fetch && (p >= 46);
      isa_i  = (p >= 46) ? op[p-46] : 1'b0;
      data_i = (p >= 2) ? c[p-2] : 1'b0;
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; sync_i = 0; isa_i = 0; data_i = 0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R9 we after reset", int'(mem_we_o), 0);
    chk("R9 wp after reset", int'(wp_o), 0);
  endtask

  task automatic t_unlocked();
    frame(1, 10'h040, acc(16'h8000, 10'h001, 2'b00));
    frame(1, 10'h000, acc(16'h8111, 10'h222, 2'b00));
    chk("R1 no write before lock", we_cnt, 0);
    frame(1, 10'h000, acc(16'h0, 10'h0, 2'b00));
  endtask

  task automatic t_basic();
    frame(1, 10'h040, acc(16'h8555, 10'h111, 2'b00));
    chk("R3 no write in fetch frame", we_cnt, 0);
    frame(1, 10'h000, acc(16'h8123, 10'h2A5, 2'b11));
    chk("R3 one write next frame", we_cnt, 1);
    chk("R8 strobe phase", we_ph, 33);
    chk("R5 address", int'(we_addr), 16'h8123);
    chk("R4 word, bits 10-11 dropped", int'(we_data), 10'h2A5);
    frame(1, 10'h000, acc(16'h8124, 10'h0AA, 2'b00));
    chk("R3 arming lapses", we_cnt, 0);
  endtask

  task automatic t_unowned();
    frame(1, 10'h040, acc(16'h0, 10'h0, 2'b00));
    frame(1, 10'h000, acc(16'h5ABC, 10'h155, 2'b00));
    chk("R6 unowned page dropped", we_cnt, 0);
    frame(1, 10'h040, acc(16'h0, 10'h0, 2'b00));
    frame(1, 10'h000, acc(16'h9FFF, 10'h3FF, 2'b00));
    chk("R6 page 9 written", we_cnt, 1);
    chk("R5 page 9 address", int'(we_addr), 16'h9FFF);
    chk("R4 all-ones word", int'(we_data), 10'h3FF);
  endtask

  task automatic t_notfetch();
    frame(0, 10'h040, acc(16'h0, 10'h0, 2'b00));
    frame(1, 10'h000, acc(16'h8001, 10'h001, 2'b00));
    chk("R2 marker low ignored", we_cnt, 0);
    frame(1, 10'h041, acc(16'h0, 10'h0, 2'b00));
    frame(1, 10'h000, acc(16'h8002, 10'h002, 2'b00));
    chk("R2 other opcode ignored", we_cnt, 0);
  endtask

  task automatic t_protect();
    frame(1, 10'h1F0, acc(16'h0, 10'h0, 2'b00));
    frame(1, 10'h040, acc(16'h0, 10'h0, 2'b00));
    chk("R7 wp set", int'(wp_o), 1);
    frame(1, 10'h000, acc(16'h8300, 10'h0F0, 2'b00));
    chk("R6 protected write dropped", we_cnt, 0);
    frame(1, 10'h1F0, acc(16'h0, 10'h0, 2'b00));
    frame(1, 10'h040, acc(16'h0, 10'h0, 2'b00));
    chk("R7 wp cleared", int'(wp_o), 0);
    frame(1, 10'h000, acc(16'h8301, 10'h001, 2'b00));
    chk("R7 write after unprotect", we_cnt, 1);
    chk("R4 word after unprotect", int'(we_data), 10'h001);
  endtask

  task automatic t_b2b();
    frame(1, 10'h040, acc(16'h0, 10'h0, 2'b00));
    frame(1, 10'h040, acc(16'h8A0A, 10'h30C, 2'b00));
    chk("R3 first of pair", we_cnt, 1);
    chk("R5 first address", int'(we_addr), 16'h8A0A);
    frame(1, 10'h000, acc(16'h9050, 10'h0C3, 2'b00));
    chk("R3 second of pair", we_cnt, 1);
    chk("R5 second address", int'(we_addr), 16'h9050);
    chk("R4 second word", int'(we_data), 10'h0C3);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_unlocked();
    t_basic();
    t_unowned();
    t_notfetch();
    t_protect();
    t_b2b();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule